// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns bytes written by a processor into an asynchronous serial bit stream. A seven-bit line control input selects the character format: five to eight data bits, an optional parity bit (odd, even, or forced to a fixed level), and one, one-and-a-half or two stop bits. A separate control bit holds the serial line low to signal a break, and the rest of the transmitter keeps running while it does.

A write places a byte into a holding register. As soon as the shift register is idle, the byte moves across and is sent. Each bit lasts a fixed number of pulses of an external baud enable, 16 by default. Two status flags let software pace its writes: holding-register-empty and transmitter-empty. An interrupt output follows holding-register-empty when its enable input is set.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, and `hold_empty` and `tx_empty` are both 1.
- R2: A character is a start bit at 0, then the data bits, least significant first. The data bit count comes from `line_ctrl[1:0]` (00 = 5, 01 = 6, 10 = 7, 11 = 8). Data bits above the selected length are never sent.
- R3: When `line_ctrl[3]` is 1, one parity bit is sent after the last data bit and before the stop bits. When it is 0, no parity bit is sent.
- R4: With parity enabled and `line_ctrl[5]` at 0, `line_ctrl[4]` = 1 gives even parity and 0 gives odd parity. The parity is computed over the data bits that are actually sent.
- R5: With parity enabled and `line_ctrl[5]` at 1, the parity bit is the fixed level `!line_ctrl[4]`.
- R6: Each start, data and parity bit lasts 16 baud-enable pulses. The stop period lasts 16 pulses when `line_ctrl[2]` is 0. When it is 1, the stop period lasts 24 pulses at 5-bit length and 32 pulses otherwise.
- R7: While `line_ctrl[6]` is 1, `txd` is 0. Character timing and both status flags behave exactly as without break.
- R8: `hold_empty` drops in the cycle after a write. When the shift register is idle, it rises again in the following cycle, as the byte enters the shift register.
- R9: `tx_empty` is 1 only when the holding register and the shift register are both empty. A byte written while a character is being sent waits in the holding register and is sent next, in write order.
- R10: `irq` equals `irq_en` AND `hold_empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle baud enable, 16 per bit time |
| line_ctrl | input | 7 | Format: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] stick, [6] break |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| irq_en | input | 1 | Enable for the holding-register-empty interrupt |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding and shift registers both empty |
| irq | output | 1 | Holding-register-empty interrupt |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that `wr_en` is asserted only while `hold_empty` is 1. A write into a full holding register would overwrite the waiting byte and break the ordering property. The bench writes only after checking `hold_empty`, drives the baud enable once every four clocks, and changes the format bits only while `tx_empty` is 1. The break bit is the one exception: it acts on the line immediately and is toggled while the line is idle.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    localparam int SX_DATA_W = 8;

    // Format fields, laid out to match line_ctrl[5:0]
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len;
    } sx_fmt_t;

    typedef enum logic [2:0] {
        SX_IDLE,
        SX_START,
        SX_DATA,
        SX_PAR,
        SX_STOP
    } sx_state_e;

    function automatic logic [3:0] sx_nbits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [SX_DATA_W-1:0] sx_mask(input logic [SX_DATA_W-1:0] d,
                                                     input logic [1:0] len);
        logic [SX_DATA_W-1:0] m;
        logic [3:0]           n;
        n = sx_nbits(len);
        m = '0;
        for (int i = 0; i < SX_DATA_W; i++) begin
            if (i < int'(n)) m[i] = d[i];
        end
        return m;
    endfunction

    function automatic logic sx_parity(input logic [SX_DATA_W-1:0] d, input sx_fmt_t f);
        logic x;
        x = ^sx_mask(d, f.len);
        if (f.stick) return ~f.even;
        return f.even ? x : ~x;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold
    import sertx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SX_DATA_W-1:0] wr_data,
    input  logic                 shift_idle,
    output logic [SX_DATA_W-1:0] hold_data,
    output logic                 hold_full,
    output logic                 xfer
);

    assign xfer = hold_full & shift_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (xfer) begin
            hold_full <= 1'b0;
        end
    end

    // R8: a transfer without a competing write leaves the holding register empty
    a_r8_xfer_empties: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wr_en) |=> !hold_full);

    // R9: a waiting byte stays put while the shifter is busy
    a_r9_waits_for_shifter: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !shift_idle && !wr_en) |=> hold_full);

endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic                 load,
    input  logic [SX_DATA_W-1:0] load_data,
    input  sx_fmt_t              load_fmt,
    output logic                 busy,
    output logic                 line
);

    localparam int CNT_W = $clog2(2*OSR + 1);
    localparam int IDX_W = $clog2(SX_DATA_W);
    localparam logic [CNT_W-1:0] T_ONE  = CNT_W'(OSR);
    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(OSR + OSR/2);
    localparam logic [CNT_W-1:0] T_TWO  = CNT_W'(2*OSR);

    sx_state_e            state;
    logic [SX_DATA_W-1:0] sh;
    logic [1:0]           len_q;
    logic                 long_q;
    logic                 pen_q;
    logic                 par_q;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [CNT_W-1:0]     limit;
    logic                 last_data;
    logic [3:0]           nb;

    always_comb begin
        nb        = sx_nbits(len_q);
        last_data = (idx == IDX_W'(nb - 4'd1));
        if (state == SX_STOP && long_q)
            limit = (len_q == 2'b00) ? T_HALF : T_TWO;
        else
            limit = T_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SX_IDLE;
            sh     <= '0;
            len_q  <= '0;
            long_q <= 1'b0;
            pen_q  <= 1'b0;
            par_q  <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
        end else if (state == SX_IDLE) begin
            if (load) begin
                state  <= SX_START;
                sh     <= load_data;
                len_q  <= load_fmt.len;
                long_q <= load_fmt.long_stop;
                pen_q  <= load_fmt.par_en;
                par_q  <= sx_parity(load_data, load_fmt);
                cnt    <= '0;
                idx    <= '0;
            end
        end else if (baud_tick) begin
            if (cnt == limit - 1'b1) begin
                cnt <= '0;
                case (state)
                    SX_START: begin
                        state <= SX_DATA;
                        idx   <= '0;
                    end
                    SX_DATA: begin
                        sh <= sh >> 1;
                        if (last_data) state <= pen_q ? SX_PAR : SX_STOP;
                        else           idx   <= idx + 1'b1;
                    end
                    SX_PAR:  state <= SX_STOP;
                    default: state <= SX_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (state)
            SX_START: line = 1'b0;
            SX_DATA:  line = sh[0];
            SX_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (state != SX_IDLE);

    // R2: the cycle after a byte is taken, the line carries the start bit
    a_r2_start_follows_load: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> (line == 1'b0));

    // R6: a character in flight can only finish on a baud pulse
    a_r6_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> busy);

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic [6:0]           line_ctrl,
    input  logic                 wr_en,
    input  logic [SX_DATA_W-1:0] wr_data,
    input  logic                 irq_en,
    output logic                 txd,
    output logic                 hold_empty,
    output logic                 tx_empty,
    output logic                 irq
);

    sx_fmt_t              fmt;
    logic                 brk;
    logic [SX_DATA_W-1:0] hold_data;
    logic                 hold_full;
    logic                 xfer;
    logic                 busy;
    logic                 line;

    assign fmt = sx_fmt_t'(line_ctrl[5:0]);
    assign brk = line_ctrl[6];

    sertx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .shift_idle (!busy),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .xfer       (xfer)
    );

    sertx_shift #(.OSR(OSR)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .load      (xfer),
        .load_data (hold_data),
        .load_fmt  (fmt),
        .busy      (busy),
        .line      (line)
    );

    assign txd        = brk ? 1'b0 : line;
    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;
    assign irq        = irq_en && hold_empty;

    // R7: break holds the line low
    a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
        line_ctrl[6] |-> !txd);

    // R9: the transmitter is never empty while a byte waits
    a_r9_empty_needs_hold: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;

    typedef struct {
        logic [7:0] d;
        logic [6:0] c;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud = 1'b0;
    logic [1:0] bcnt = 2'd0;
    logic [6:0] ctrl = 7'h03;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en = 1'b0;
    logic       txd, hold_empty, tx_empty, irq;

    int    nchk = 0;
    int    nfail = 0;
    bit    mon_en = 1'b1;
    bit    done = 1'b0;
    item_t q[$];

    sertx_top dut (
        .clk(clk), .rst(rst), .baud_tick(baud), .line_ctrl(ctrl),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        bcnt <= bcnt + 2'd1;
        baud <= (bcnt == 2'd3);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (baud) c++;
        end
    endtask

    function automatic logic exp_par(input item_t it);
        int ones;
        ones = $countones(it.d & 8'((9'd1 << (5 + it.c[1:0])) - 1));
        if (it.c[5]) return !it.c[4];
        return it.c[4] ? logic'(ones % 2) : logic'(!(ones % 2));
    endfunction

    // Monitor: pops one expected item per start bit and samples mid-bit
    initial begin
        bit    prev = 1'b1;
        item_t it;
        int    n;
        forever begin
            @(negedge clk);
            if (mon_en && prev && !txd) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9 frame with nothing queued", 1, 0);
                end else begin
                    it = q.pop_front();
                    n  = 5 + int'(it.c[1:0]);
                    wait_ticks(8);
                    check(txd == 1'b0, "R2 start bit", int'(txd), 0);
                    for (int i = 0; i < n; i++) begin
                        wait_ticks(16);
                        check(txd == it.d[i], "R2 data bit", int'(txd), int'(it.d[i]));
                    end
                    if (it.c[3]) begin
                        wait_ticks(16);
                        if (it.c[5]) check(txd == exp_par(it), "R5 stick parity", int'(txd), int'(exp_par(it)));
                        else         check(txd == exp_par(it), "R3 R4 parity bit", int'(txd), int'(exp_par(it)));
                    end
                    wait_ticks(16);
                    check(txd == 1'b1, "R6 stop bit level", int'(txd), 1);
                end
                prev = 1'b1;
            end else begin
                prev = txd;
            end
        end
    end

    // Write a byte; optionally check the R8/R10 handshake around the transfer
    task automatic send(input logic [7:0] d, input bit push, input bit chk);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_data = d;
        if (push) q.push_back('{d: d, c: ctrl});
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (chk) begin
            @(negedge clk);
            check(hold_empty == 1'b0, "R8 hold_empty low after write", int'(hold_empty), 0);
            check(irq == 1'b0, "R10 irq low while holding", int'(irq), 0);
            @(negedge clk);
            check(hold_empty == 1'b1, "R8 hold_empty set on transfer", int'(hold_empty), 1);
            check(tx_empty == 1'b0, "R9 tx_empty low while shifting", int'(tx_empty), 0);
            check(irq == irq_en, "R10 irq follows hold_empty", int'(irq), int'(irq_en));
        end
    endtask

    // Count baud pulses until tx_empty; also count cycles with txd high
    task automatic measure(output int ticks, output int highs);
        ticks = 0;
        highs = 0;
        while (!tx_empty) begin
            if (baud) ticks++;
            if (txd) highs++;
            @(negedge clk);
        end
    endtask

    task automatic frame(input logic [6:0] c, input logic [7:0] d, input int exp_ticks);
        int t, h;
        ctrl = c;
        send(d, 1'b1, 1'b1);
        measure(t, h);
        check(t == exp_ticks, "R6 frame length in baud pulses", t, exp_ticks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog R1 R9 run hung actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int t, h;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R1 idle line", int'(txd), 1);
        check(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
        check(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
        check(irq == 1'b0, "R10 irq off when disabled", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R10 irq on when enabled", int'(irq), 1);

        frame(7'h03, 8'hA5, 160);   // 8 bits, no parity, 1 stop
        frame(7'h00, 8'hF3, 112);   // 5 bits, upper bits dropped
        frame(7'h04, 8'h16, 120);   // 5 bits, 1.5 stop
        frame(7'h05, 8'h2A, 144);   // 6 bits, 2 stop
        frame(7'h1A, 8'h5B, 160);   // 7 bits, even parity
        frame(7'h0A, 8'h01, 160);   // 7 bits, odd parity
        frame(7'h0D, 8'h2E, 160);   // 6 bits, odd parity, 2 stop
        frame(7'h2B, 8'h00, 176);   // 8 bits, stick -> 1
        frame(7'h3B, 8'hFF, 176);   // 8 bits, stick -> 0

        // R9: back-to-back, second byte waits in the holding register
        ctrl = 7'h03;
        send(8'h3C, 1'b1, 1'b1);
        send(8'hC3, 1'b1, 1'b0);
        @(negedge clk);
        check(hold_empty == 1'b0, "R9 byte waits while busy", int'(hold_empty), 0);
        check(tx_empty == 1'b0, "R9 not empty while busy", int'(tx_empty), 0);
        while (!hold_empty) @(negedge clk);
        check(tx_empty == 1'b0, "R9 second byte in shifter", int'(tx_empty), 0);
        while (!tx_empty) @(negedge clk);
        repeat (8) @(negedge clk);
        check(q.size() == 0, "R9 all queued bytes sent in order", q.size(), 0);

        // R7: break forces the line low, timing and flags unchanged
        mon_en = 1'b0;
        ctrl = 7'h43;
        @(negedge clk);
        check(txd == 1'b0, "R7 break on idle line", int'(txd), 0);
        send(8'h5A, 1'b0, 1'b1);
        measure(t, h);
        check(t == 160, "R7 frame length under break", t, 160);
        check(h == 0, "R7 line stays low", h, 0);
        ctrl = 7'h03;
        @(negedge clk);
        check(txd == 1'b1, "R7 line released", int'(txd), 1);
        mon_en = 1'b1;
        frame(7'h03, 8'h81, 160);

        repeat (8) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule